// File: doc/BRIEF.md
# AES-128 Round Key Generator

This unit keeps a 128-bit cipher key and turns it into the eleven round keys that an iterative AES-128 datapath uses. The key arrives 32 bits at a time. A two-bit select picks which quarter of the key each write updates, and the quarters may be written in any order.

A one-cycle expand pulse starts a sequential expansion. The sequencer produces one 32-bit schedule word per clock. It then idles for padding cycles so that the whole operation always takes exactly 52 cycles. When the expansion ends, a key-ready flag rises. Any key write clears that flag, and a write that arrives mid-expansion cancels the expansion.

The cipher datapath reads a whole 128-bit round key combinationally through a 4-bit round index. A reverse input flips the indexing, so a decrypting datapath can count its rounds upward and still receive the keys from last to first.

Top module: `aes_key_unit`

## Requirements
- R1: The select input maps key quarters as follows: 00 writes key bits [31:0], 01 writes [63:32], 10 writes [95:64] and 11 writes [127:96]. After expansion, round key 0 equals the 128-bit key assembled this way.
- R2: The four quarters may be written in any order, and the result is the same key.
- R3: A write strobe sampled at a clock edge makes key-ready 0 after that edge.
- R4: Take the edge at which the expand strobe is sampled as edge 0. Key-ready stays 0 through edge 51 and becomes 1 at edge 52.
- R5: Key-ready is 0 after the synchronous active-high reset.
- R6: Round keys 0 to 10 match the AES-128 key schedule. That schedule uses RotWord, SubWord and the round constants 01,02,04,08,10,20,40,80,1B,36. Round key r is the concatenation {w[4r], w[4r+1], w[4r+2], w[4r+3]}, with w[4r] in bits [127:96].
- R7: With reverse at 0, the read port returns round key `rd_round`. With reverse at 1, it returns round key `10 - rd_round`.
- R8: A key write during an expansion aborts it. Key-ready then stays 0 until a new expand strobe completes.
- R9: A round index above 10 reads as all zeros, in either direction.
- R10: While no write or expand strobe arrives and no expansion is running, key-ready holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| key_wr | input | 1 | Write strobe for one key quarter |
| key_sel | input | 2 | Selects the quarter to write (00 = least significant) |
| key_word | input | 32 | Data for the key quarter |
| key_exp | input | 1 | One-cycle strobe that starts expansion |
| key_ready | output | 1 | The expanded schedule is valid |
| rd_round | input | 4 | Round index for the read port |
| rd_reverse | input | 1 | 1: read round 10 - rd_round |
| rd_key | output | 128 | Selected round key (combinational) |

## Verification
Key-ready is due at fixed offsets from each stimulus:
- It falls one edge after a write strobe.
- It is checked low 51 edges after the expand strobe's sampling edge and high at the 52nd; the bench samples on falling edges that it counts from the strobe.

The round keys are compared only once key-ready is high. The read port is combinational, so each probe is driven after a rising edge and compared at the following falling edge. A scoreboard queue holds the expected key from a software model of the schedule. The abort case writes a word twenty cycles into an expansion, then checks that key-ready is still low well past the 52-cycle point.

// File: rtl/aes_ks_pkg.sv
package aes_ks_pkg;
    localparam int WORD_W      = 32;
    localparam int KEY_WORDS   = 4;
    localparam int ROUNDS      = 10;
    localparam int RK_COUNT    = ROUNDS + 1;
    localparam int SCHED_WORDS = KEY_WORDS * RK_COUNT;
    localparam int GEN_WORDS   = SCHED_WORDS - KEY_WORDS;
    localparam int ADDR_W      = $clog2(SCHED_WORDS);
    localparam int BLOCK_W     = KEY_WORDS * WORD_W;

    typedef logic [WORD_W-1:0]  word_t;
    typedef logic [BLOCK_W-1:0] block_t;
    typedef logic [ADDR_W-1:0]  waddr_t;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_GEN  = 2'd1,
        SEQ_PAD  = 2'd2
    } seq_phase_e;

    // One schedule step handed from the sequencer to the generator and the store
    typedef struct packed {
        logic   load;   // copy cipher key into window and words 0..3
        logic   step;   // produce one new word
        logic   rot;    // this word takes RotWord/SubWord/Rcon
        waddr_t idx;    // destination word index
    } ks_ctrl_t;

    function automatic logic [7:0] gf_xtime(input logic [7:0] a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
    endfunction

    function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] acc;
        logic [7:0] sh;
        acc = 8'h00;
        sh  = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc = acc ^ sh;
            sh = gf_xtime(sh);
        end
        return acc;
    endfunction

    function automatic logic [7:0] rotl8(input logic [7:0] b, input int n);
        return (b << n) | (b >> (8 - n));
    endfunction

    // Multiplicative inverse as x^254 (product of x^2 .. x^128), then affine map
    function automatic logic [7:0] sbox(input logic [7:0] x);
        logic [7:0] sq;
        logic [7:0] inv;
        sq  = x;
        inv = 8'h01;
        for (int i = 0; i < 7; i++) begin
            sq  = gf_mul(sq, sq);
            inv = gf_mul(inv, sq);
        end
        return inv ^ rotl8(inv, 1) ^ rotl8(inv, 2) ^ rotl8(inv, 3)
                   ^ rotl8(inv, 4) ^ 8'h63;
    endfunction

    function automatic word_t sub_word(input word_t w);
        word_t r;
        for (int b = 0; b < 4; b++) r[8*b +: 8] = sbox(w[8*b +: 8]);
        return r;
    endfunction

    function automatic word_t rot_word(input word_t w);
        return {w[23:0], w[31:24]};
    endfunction
endpackage

// File: rtl/aes_key_word_bank.sv
module aes_key_word_bank
    import aes_ks_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr,
    input  logic [1:0] sel,
    input  word_t      din,
    output block_t     key
);
    word_t quarter [KEY_WORDS];

    for (genvar q = 0; q < KEY_WORDS; q++) begin : g_quarter
        always_ff @(posedge clk) begin
            if (rst)                          quarter[q] <= '0;
            else if (wr && (sel == 2'(q)))    quarter[q] <= din;
        end
        assign key[q*WORD_W +: WORD_W] = quarter[q];
    end
endmodule

// File: rtl/aes_kexp_sequencer.sv
module aes_kexp_sequencer
    import aes_ks_pkg::*;
#(
    parameter int LATENCY = 52
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     key_wr,
    input  logic     key_exp,
    output ks_ctrl_t ctrl,
    output logic     busy,
    output logic     ready
);
    localparam int CNT_W = $clog2(LATENCY);

    seq_phase_e       phase;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= SEQ_IDLE;
            cnt   <= '0;
            ready <= 1'b0;
        end else if (key_wr) begin
            phase <= SEQ_IDLE;
            cnt   <= '0;
            ready <= 1'b0;
        end else if (key_exp) begin
            phase <= SEQ_GEN;
            cnt   <= '0;
            ready <= 1'b0;
        end else begin
            unique case (phase)
                SEQ_GEN: begin
                    cnt <= cnt + 1'b1;
                    if (cnt == CNT_W'(GEN_WORDS - 1)) phase <= SEQ_PAD;
                end
                SEQ_PAD: begin
                    cnt <= cnt + 1'b1;
                    if (cnt == CNT_W'(LATENCY - 1)) begin
                        phase <= SEQ_IDLE;
                        ready <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    assign busy      = (phase != SEQ_IDLE);
    assign ctrl.load = key_exp && !key_wr;
    assign ctrl.step = (phase == SEQ_GEN) && !key_wr && !key_exp;
    assign ctrl.rot  = (cnt[1:0] == 2'b00);
    assign ctrl.idx  = ADDR_W'(cnt) + ADDR_W'(KEY_WORDS);
endmodule

// File: rtl/aes_kexp_word_gen.sv
module aes_kexp_word_gen
    import aes_ks_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  ks_ctrl_t ctrl,
    input  block_t   key,
    output word_t    new_word
);
    word_t      win [KEY_WORDS];   // win[0] oldest, win[KEY_WORDS-1] newest
    logic [7:0] rcon;
    word_t      temp;

    always_comb begin
        temp = win[KEY_WORDS-1];
        if (ctrl.rot) temp = sub_word(rot_word(temp)) ^ {rcon, 24'h0};
        new_word = win[0] ^ temp;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < KEY_WORDS; i++) win[i] <= '0;
            rcon <= 8'h01;
        end else if (ctrl.load) begin
            for (int i = 0; i < KEY_WORDS; i++)
                win[i] <= key[(KEY_WORDS-1-i)*WORD_W +: WORD_W];
            rcon <= 8'h01;
        end else if (ctrl.step) begin
            for (int i = 0; i < KEY_WORDS - 1; i++) win[i] <= win[i+1];
            win[KEY_WORDS-1] <= new_word;
            if (ctrl.rot) rcon <= gf_xtime(rcon);
        end
    end
endmodule

// File: rtl/aes_round_key_store.sv
module aes_round_key_store
    import aes_ks_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  ks_ctrl_t   ctrl,
    input  block_t     key,
    input  word_t      new_word,
    input  logic [3:0] rd_round,
    input  logic       rd_reverse,
    output block_t     rd_key
);
    word_t sched [SCHED_WORDS];

    for (genvar w = 0; w < SCHED_WORDS; w++) begin : g_word
        if (w < KEY_WORDS) begin : g_key
            always_ff @(posedge clk) begin
                if (rst)            sched[w] <= '0;
                else if (ctrl.load) sched[w] <= key[(KEY_WORDS-1-w)*WORD_W +: WORD_W];
            end
        end else begin : g_gen
            always_ff @(posedge clk) begin
                if (rst)                                        sched[w] <= '0;
                else if (ctrl.step && ctrl.idx == ADDR_W'(w))   sched[w] <= new_word;
            end
        end
    end

    logic [4:0] eff;
    always_comb begin
        eff    = rd_reverse ? (5'(ROUNDS) - {1'b0, rd_round}) : {1'b0, rd_round};
        rd_key = '0;
        if (rd_round <= 4'(ROUNDS)) begin
            for (int r = 0; r < RK_COUNT; r++) begin
                if (eff == 5'(r))
                    rd_key = {sched[4*r], sched[4*r+1], sched[4*r+2], sched[4*r+3]};
            end
        end
    end
endmodule

// File: rtl/aes_key_unit.sv
module aes_key_unit
    import aes_ks_pkg::*;
#(
    parameter int EXPAND_LATENCY = 52
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         key_wr,
    input  logic [1:0]   key_sel,
    input  logic [31:0]  key_word,
    input  logic         key_exp,
    output logic         key_ready,
    input  logic [3:0]   rd_round,
    input  logic         rd_reverse,
    output logic [127:0] rd_key
);
    block_t   cipher_key;
    ks_ctrl_t ctrl;
    word_t    gen_word;
    logic     seq_busy;

    aes_key_word_bank u_bank (
        .clk (clk), .rst (rst), .wr (key_wr), .sel (key_sel),
        .din (key_word), .key (cipher_key)
    );

    aes_kexp_sequencer #(.LATENCY(EXPAND_LATENCY)) u_seq (
        .clk (clk), .rst (rst), .key_wr (key_wr), .key_exp (key_exp),
        .ctrl (ctrl), .busy (seq_busy), .ready (key_ready)
    );

    aes_kexp_word_gen u_gen (
        .clk (clk), .rst (rst), .ctrl (ctrl), .key (cipher_key),
        .new_word (gen_word)
    );

    aes_round_key_store u_store (
        .clk (clk), .rst (rst), .ctrl (ctrl), .key (cipher_key),
        .new_word (gen_word), .rd_round (rd_round),
        .rd_reverse (rd_reverse), .rd_key (rd_key)
    );
endmodule

// File: rtl/aes_key_unit_chk.sv
module aes_key_unit_chk (
    input logic clk,
    input logic rst,
    input logic key_wr,
    input logic key_exp,
    input logic key_ready,
    input logic seq_busy
);
    localparam int DUE = 52;
    logic [6:0] since_exp;

    always_ff @(posedge clk) begin
        if (rst)                   since_exp <= 7'h7f;
        else if (key_exp)          since_exp <= '0;
        else if (since_exp != 7'h7f) since_exp <= since_exp + 1'b1;
    end

    assert_reset_clears_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !key_ready);

    assert_write_drops_ready_R3: assert property (@(posedge clk) disable iff (rst)
        key_wr |=> !key_ready);

    assert_ready_on_time_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(key_ready) |-> (since_exp == 7'(DUE)));

    assert_expand_starts_R4: assert property (@(posedge clk) disable iff (rst)
        (key_exp && !key_wr) |=> (seq_busy && !key_ready));

    assert_abort_R8: assert property (@(posedge clk) disable iff (rst)
        (seq_busy && key_wr) |=> (!seq_busy && !key_ready));

    assert_ready_holds_R10: assert property (@(posedge clk) disable iff (rst)
        (!key_wr && !key_exp && !seq_busy) |=> $stable(key_ready));
endmodule

bind aes_key_unit aes_key_unit_chk u_chk (
    .clk (clk), .rst (rst), .key_wr (key_wr), .key_exp (key_exp),
    .key_ready (key_ready), .seq_busy (seq_busy)
);

// File: tb/aes_key_unit_bench.sv
`timescale 1ns/1ps
module aes_key_unit_bench;
    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         key_wr = 1'b0;
    logic [1:0]   key_sel = 2'b00;
    logic [31:0]  key_word = '0;
    logic         key_exp = 1'b0;
    logic         key_ready;
    logic [3:0]   rd_round = '0;
    logic         rd_reverse = 1'b0;
    logic [127:0] rd_key;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #4 clk = ~clk;

    aes_key_unit u_aes_key_unit (
        .clk (clk), .rst (rst), .key_wr (key_wr), .key_sel (key_sel),
        .key_word (key_word), .key_exp (key_exp), .key_ready (key_ready),
        .rd_round (rd_round), .rd_reverse (rd_reverse), .rd_key (rd_key)
    );

    // ---------------- software model ----------------
    logic [31:0] mw [44];

    function automatic logic [7:0] m_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] p;
        p = 0;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) p ^= a;
            a = {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
        end
        return p;
    endfunction

    function automatic logic [7:0] m_sbox(input logic [7:0] x);
        logic [7:0] inv;
        logic [7:0] s;
        logic [7:0] c;
        inv = 0;
        for (int y = 1; y < 256; y++)
            if (x != 0 && m_mul(x, 8'(y)) == 8'h01) inv = 8'(y);
        c = 8'h63;
        for (int i = 0; i < 8; i++)
            s[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8]
                 ^ inv[(i+7)%8] ^ c[i];
        return s;
    endfunction

    task automatic build_model(input logic [127:0] k);
        logic [31:0] t;
        logic [7:0]  rc;
        rc = 8'h01;
        for (int i = 0; i < 4; i++) mw[i] = k[127-32*i -: 32];
        for (int i = 4; i < 44; i++) begin
            t = mw[i-1];
            if (i % 4 == 0) begin
                t = {t[23:0], t[31:24]};
                t = {m_sbox(t[31:24]), m_sbox(t[23:16]), m_sbox(t[15:8]), m_sbox(t[7:0])};
                t[31:24] ^= rc;
                rc = m_mul(rc, 8'h02);
            end
            mw[i] = mw[i-4] ^ t;
        end
    endtask

    function automatic logic [127:0] model_rk(input int r);
        return {mw[4*r], mw[4*r+1], mw[4*r+2], mw[4*r+3]};
    endfunction

    // ---------------- scoreboard ----------------
    typedef struct {
        string        req;
        int           idx;
        logic [127:0] exp;
    } sb_item_t;
    sb_item_t sbq [$];

    always @(negedge clk) begin
        if (sbq.size() != 0) begin
            sb_item_t it;
            it = sbq.pop_front();
            n_checks++;
            if (rd_key !== it.exp) begin
                n_fail++;
                $display("FAIL %s round %0d: got %h expected %h", it.req, it.idx, rd_key, it.exp);
            end
        end
    end

    task automatic probe(input int idx, input bit rev, input logic [127:0] exp, input string req);
        sb_item_t it;
        @(posedge clk);
        #1;
        rd_round   = 4'(idx);
        rd_reverse = rev;
        it.req = req; it.idx = idx; it.exp = exp;
        sbq.push_back(it);
        @(negedge clk);
        #1;
    endtask

    task automatic check_ready(input logic exp, input string req);
        n_checks++;
        if (key_ready !== exp) begin
            n_fail++;
            $display("FAIL %s key_ready: got %b expected %b", req, key_ready, exp);
        end
    endtask

    task automatic wr_word(input logic [1:0] sel, input logic [31:0] val);
        @(negedge clk);
        key_wr = 1'b1; key_sel = sel; key_word = val;
        @(negedge clk);
        key_wr = 1'b0;
    endtask

    task automatic start_expand;
        @(negedge clk);
        key_exp = 1'b1;
        @(negedge clk);
        key_exp = 1'b0;
    endtask

    task automatic report;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            report();
        end
    end

    localparam logic [127:0] KEY_A = 128'h2b7e151628aed2a6abf7158809cf4f3c;
    localparam logic [127:0] KEY_B = 128'h000102030405060708090a0b0c0d0e0f;

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_ready(1'b0, "R5");

        // R1/R2: quarters written out of order
        wr_word(2'b11, KEY_A[127:96]);
        wr_word(2'b00, KEY_A[31:0]);
        wr_word(2'b10, KEY_A[95:64]);
        wr_word(2'b01, KEY_A[63:32]);
        build_model(KEY_A);

        // R4: exact latency
        start_expand();
        repeat (51) @(negedge clk);
        check_ready(1'b0, "R4 edge51");
        @(negedge clk);
        check_ready(1'b1, "R4 edge52");

        probe(0, 1'b0, KEY_A, "R1 R2 round0 equals key");
        probe(1, 1'b0, 128'ha0fafe1788542cb123a339392a6c7605, "R6 known round1");
        probe(10, 1'b0, 128'hd014f9a8c9ee2589e13f0cc8b6630ca6, "R6 known round10");
        for (int r = 0; r < 11; r++) probe(r, 1'b0, model_rk(r), "R6 model");
        probe(0, 1'b1, model_rk(10), "R7 reverse 0");
        probe(3, 1'b1, model_rk(7), "R7 reverse 3");
        probe(10, 1'b1, model_rk(0), "R7 reverse 10");
        probe(11, 1'b0, '0, "R9 index 11");
        probe(15, 1'b1, '0, "R9 index 15 reverse");

        // R10: idle, flag holds
        repeat (30) @(negedge clk);
        check_ready(1'b1, "R10");

        // R3: write drops ready on the next edge
        wr_word(2'b00, KEY_B[31:0]);
        check_ready(1'b0, "R3");
        wr_word(2'b01, KEY_B[63:32]);
        wr_word(2'b10, KEY_B[95:64]);
        wr_word(2'b11, 32'hdeadbeef);

        // R8: abort mid-expansion
        start_expand();
        repeat (20) @(negedge clk);
        wr_word(2'b11, KEY_B[127:96]);
        repeat (60) @(negedge clk);
        check_ready(1'b0, "R8");

        // new key after abort
        build_model(KEY_B);
        start_expand();
        repeat (51) @(negedge clk);
        check_ready(1'b0, "R4 second edge51");
        @(negedge clk);
        check_ready(1'b1, "R4 second edge52");
        probe(0, 1'b0, KEY_B, "R1 second key");
        for (int r = 0; r < 11; r++) probe(r, 1'b0, model_rk(r), "R6 second key");
        probe(2, 1'b1, model_rk(8), "R7 second key");

        repeat (2) @(negedge clk);
        done = 1;
        report();
    end
endmodule